// File: doc/BRIEF.md
# Four-Bank Interleaved Word Memory

This block is a byte-addressed memory of 16-bit words. Every access must be word-aligned. Storage is divided into four banks, and consecutive words go to consecutive banks. Each bank works through one access at a time, and an access holds its bank for a fixed four-cycle window. Requests that go to different banks therefore overlap. A new request can be accepted on every clock edge, provided its bank is idle.

A read returns its word on the data output two clock edges after it is accepted. The output then holds that word until the next read returns. A write is stored at the end of its bank's busy window, so a read accepted as soon as the bank frees already sees the new word.

A request to a bank that is still busy is dropped, and stall is raised for it in the same cycle. A request that is misaligned, or that asks for a read and a write together, raises err. Such a request has no other effect. The caller must repeat any dropped or erroneous request itself.

On reset the contents are set to a fixed, computable pattern, so a test can start from known data. The number of words per bank is a parameter.

Top module: `banked_word_mem`

## Requirements
- R1: The target bank is `addr[2:1]`. The word row inside the bank is `addr[8:3]` (with 64 words per bank). Address bits above the row are ignored, so addresses that differ only in those bits name the same word.
- R2: A read accepted at clock edge k updates `rdata` at edge k+2 with the word stored at that address. `rdata` keeps its value in every other cycle.
- R3: A write accepted at edge k updates memory no later than edge k+3. A read accepted at edge k+4 to the same word returns the written data.
- R4: After a bank accepts a request at edge k, its `bank_busy` bit is high from edge k until edge k+3 and low again after edge k+3, so a new request to it is accepted at edge k+4.
- R5: A read or write that targets a bank whose `bank_busy` bit is high raises `stall` in the same cycle. The request is dropped: it changes no memory, returns no data and does not extend the busy window.
- R6: A valid request to an idle bank is accepted in the cycle right after another bank accepted a request. No stall is raised for it.
- R7: `err` is high in any cycle in which `rd_en` or `wr_en` is high with `addr[0]`=1, or in which both are high. Such a request writes nothing, returns nothing, occupies no bank and never raises `stall`.
- R8: Synchronous active-low reset clears all busy bits and clears `rdata` to zero. It also sets global word w (`w = addr[8:1]`) to `(w*257 XOR 0x5A5A)`, truncated to 16 bits.
- R9: A cycle with `rd_en` and `wr_en` both low raises neither `err` nor `stall`, and it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 16 | Byte address of the request |
| wdata | input | 16 | Write data |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| rdata | output | 16 | Data of the most recently returned read |
| stall | output | 1 | Request dropped because its bank is busy |
| bank_busy | output | 4 | Per-bank flag: the bank cannot accept a request now |
| err | output | 1 | Request is misaligned or asks for a read and a write together |

## Verification
On every cycle, assertions check the following:
- a bank that accepts a request shows busy on the next cycle;
- an accepted read produces a bank return two edges later;
- at most one bank returns data at a time;
- stall occurs only while the target bank is busy;
- an erroneous request arriving while all banks are idle leaves them idle.

Other behaviours can only be shown by the bench's scenarios, which compare against a bench-side model of memory contents and bank timers. These are:
- the data values that come back, including the reset pattern;
- when a write becomes visible;
- aliasing of the high address bits;
- that dropped and erroneous requests leave memory untouched.

// File: rtl/bmem_pkg.sv
// Shared definitions for the banked word memory.
// Assumes: callers size the init pattern down to their data width.
package bmem_pkg;

    // Classification of the request presented in the current cycle.
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_RD   = 2'd1,
        REQ_WR   = 2'd2,
        REQ_BAD  = 2'd3
    } req_kind_e;

    // Contents of global word w after reset.
    function automatic logic [31:0] init_word(input int unsigned w);
        return (w * 32'd257) ^ 32'h0000_5A5A;
    endfunction

endpackage

// File: rtl/bmem_decode.sv
// Request decoder: classifies the request and splits the address into
// bank number and row.
// Assumes: ADDR_W leaves room for the alignment bit, bank bits and row bits.
module bmem_decode #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 2,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                rd_i,
    input  logic                wr_i,
    output bmem_pkg::req_kind_e kind_o,
    output logic [BANK_W-1:0]   bank_o,
    output logic [IDX_W-1:0]    idx_o
);
    localparam int TOP = IDX_W + BANK_W + 1;

    // Classify: both strobes, or a misaligned strobe, is an error.
    always_comb begin
        if ((rd_i && wr_i) || ((rd_i || wr_i) && addr_i[0]))
            kind_o = bmem_pkg::REQ_BAD;
        else if (rd_i)
            kind_o = bmem_pkg::REQ_RD;
        else if (wr_i)
            kind_o = bmem_pkg::REQ_WR;
        else
            kind_o = bmem_pkg::REQ_NONE;
    end

    // Bank number comes from the low word bits, the row from the bits above them.
    assign bank_o = addr_i[BANK_W:1];
    assign idx_o  = addr_i[TOP-1:BANK_W+1];

    // Address bits above the row alias and are deliberately dropped.
    generate
        if (ADDR_W > TOP) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^addr_i[ADDR_W-1:TOP];
        end
    endgenerate
endmodule

// File: rtl/bmem_bank.sv
// One memory bank. It accepts one request, then stays busy for BUSY_CYC
// cycles. Read data leaves one edge after acceptance (the top adds a second
// register). A write is stored on the last edge of the busy window.
// Assumes: BUSY_CYC >= 2, and sel_i is only high for a valid read or write.
module bmem_bank #(
    parameter int DATA_W   = 16,
    parameter int IDX_W    = 6,
    parameter int DEPTH    = 64,
    parameter int NBANK    = 4,
    parameter int BANK_ID  = 0,
    parameter int BUSY_CYC = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_i,
    input  bmem_pkg::req_kind_e kind_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic                busy_o,
    output logic                rvalid_o,
    output logic [DATA_W-1:0]   rdata_o
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  p_idx;
    logic [DATA_W-1:0] p_wd;
    logic              p_wr;
    logic              rd_stage;
    logic              accept;
    logic              commit;

    assign busy_o = (cnt != '0);
    assign accept = sel_i && !busy_o;
    assign commit = p_wr && (cnt == CNT_W'(1));

    // Occupancy timer: loaded on accept, counts down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (accept)
            cnt <= CNT_W'(BUSY_CYC - 1);
        else if (busy_o)
            cnt <= cnt - CNT_W'(1);
    end

    // Capture the pending row, write data and operation of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_idx    <= '0;
            p_wd     <= '0;
            p_wr     <= 1'b0;
            rd_stage <= 1'b0;
        end else begin
            rd_stage <= accept && (kind_i == bmem_pkg::REQ_RD);
            if (accept) begin
                p_idx <= idx_i;
                p_wd  <= wdata_i;
                p_wr  <= (kind_i == bmem_pkg::REQ_WR);
            end else if (commit) begin
                p_wr <= 1'b0;
            end
        end
    end

    // Storage: load the pattern on reset, store the pending write at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= DATA_W'(bmem_pkg::init_word(i * NBANK + BANK_ID));
        end else if (commit) begin
            mem[p_idx] <= p_wd;
        end
    end

    // Read stage: fetch the row one edge after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_o <= 1'b0;
            rdata_o  <= '0;
        end else begin
            rvalid_o <= rd_stage;
            if (rd_stage)
                rdata_o <= mem[p_idx];
        end
    end

    // Accepting must make the bank busy on the next cycle.
    assert_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);

    // An accepted read returns from the bank two edges later.
    assert_read_return_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind_i == bmem_pkg::REQ_RD) |=> ##1 rvalid_o);
endmodule

// File: rtl/banked_word_mem.sv
// Four-bank interleaved word memory. It decodes each request, routes it to
// the bank picked by the low word-address bits, reports stall or err, and
// registers returning read data onto rdata.
// Assumes: the requester retries dropped requests; no buffering at the edge.
module banked_word_mem #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int NBANK    = 4,
    parameter int DEPTH    = 64,
    parameter int BUSY_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       addr,
    input  logic [15:0]       wdata,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic [15:0]       rdata,
    output logic              stall,
    output logic [3:0]        bank_busy,
    output logic              err
);
    localparam int BANK_W = $clog2(NBANK);
    localparam int IDX_W  = $clog2(DEPTH);

    bmem_pkg::req_kind_e kind;
    logic [BANK_W-1:0]   bank;
    logic [IDX_W-1:0]    idx;
    logic [NBANK-1:0]    sel;
    logic [NBANK-1:0]    busy;
    logic [NBANK-1:0]    rvalid;
    logic [DATA_W-1:0]   bank_rd [NBANK];
    logic [DATA_W-1:0]   rd_mux;
    logic                good;

    bmem_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_dec (
        .addr_i (addr),
        .rd_i   (rd_en),
        .wr_i   (wr_en),
        .kind_o (kind),
        .bank_o (bank),
        .idx_o  (idx)
    );

    assign good = (kind == bmem_pkg::REQ_RD) || (kind == bmem_pkg::REQ_WR);

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            assign sel[b] = good && (bank == BANK_W'(b));
            bmem_bank #(
                .DATA_W(DATA_W), .IDX_W(IDX_W), .DEPTH(DEPTH),
                .NBANK(NBANK), .BANK_ID(b), .BUSY_CYC(BUSY_CYC)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .sel_i    (sel[b]),
                .kind_i   (kind),
                .idx_i    (idx),
                .wdata_i  (wdata),
                .busy_o   (busy[b]),
                .rvalid_o (rvalid[b]),
                .rdata_o  (bank_rd[b])
            );
        end
    endgenerate

    // Flag outputs: a dropped valid request stalls, a malformed one errs.
    assign stall     = |(sel & busy);
    assign err       = (kind == bmem_pkg::REQ_BAD);
    assign bank_busy = busy;

    // Merge bank returns; at most one bank returns in any cycle.
    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NBANK; b++)
            if (rvalid[b])
                rd_mux = rd_mux | bank_rd[b];
    end

    // Output register: the second stage of the read latency, held between returns.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (|rvalid)
            rdata <= rd_mux;
    end

    // Only one bank may return data in a cycle.
    assert_single_return_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rvalid));

    // A stall only happens while the addressed bank is busy.
    assert_stall_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> bank_busy[addr[2:1]]);

    // An erroneous request never occupies a bank.
    assert_err_no_occupy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && bank_busy == 4'b0000) |=> (bank_busy == 4'b0000));
endmodule

// File: tb/banked_word_mem_tb.sv
`timescale 1ns/1ps
module banked_word_mem_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] rdata;
    logic        stall;
    logic [3:0]  bank_busy;
    logic        err;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench model state
    logic [15:0] sh [256];
    int          m_cnt [4];
    logic        m_pw  [4];
    logic [7:0]  m_pwa [4];
    logic [15:0] m_pwd [4];
    logic        r0_v = 1'b0, r1_v = 1'b0;
    logic [15:0] r0_d = '0, r1_d = '0, exp_dout = '0;

    always #4 clk = ~clk;

    banked_word_mem u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .wr_en(wr_en), .rdata(rdata), .stall(stall),
        .bank_busy(bank_busy), .err(err)
    );

    function automatic logic [15:0] pattern(input int w);
        return 16'((w * 257) ^ 32'h5A5A);
    endfunction

    task automatic chk(input string req, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual %h expected %h", req, tag, act, exp);
        end
    endtask

    // One request cycle: check the combinational flags, then step the model.
    task automatic step(input logic r, input logic w, input logic [15:0] a,
                        input logic [15:0] d, input string tag);
        int          b;
        logic        v, es, ee, acc;
        logic [3:0]  eb;
        @(negedge clk);
        rd_en = r; wr_en = w; addr = a; wdata = d;
        #1;
        b  = int'(a[2:1]);
        v  = (r ^ w) && !a[0];
        ee = (r | w) && (a[0] || (r && w));
        for (int k = 0; k < 4; k++) eb[k] = (m_cnt[k] != 0);
        es = v && eb[b];
        chk("R7", tag, 32'(err), 32'(ee));
        chk("R5", tag, 32'(stall), 32'(es));
        chk("R4", tag, 32'(bank_busy), 32'(eb));
        acc = v && !es;
        @(posedge clk);
        #1;
        for (int k = 0; k < 4; k++) begin
            if (m_cnt[k] == 1 && m_pw[k]) begin
                sh[m_pwa[k]] = m_pwd[k];
                m_pw[k] = 1'b0;
            end
            if (m_cnt[k] != 0) m_cnt[k]--;
        end
        if (acc) begin
            m_cnt[b] = 3;
            if (w) begin
                m_pw[b] = 1'b1; m_pwa[b] = a[8:1]; m_pwd[b] = d;
            end
        end
        if (r1_v) exp_dout = r1_d;
        chk("R2", tag, 32'(rdata), 32'(exp_dout));
        r1_v = r0_v; r1_d = r0_d;
        r0_v = acc && r; r0_d = sh[a[8:1]];
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        for (int i = 0; i < 256; i++) sh[i] = pattern(i);
        for (int k = 0; k < 4; k++) begin
            m_cnt[k] = 0; m_pw[k] = 1'b0; m_pwa[k] = '0; m_pwd[k] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state and reset contents
        step(0, 0, 16'h0000, 16'h0, "R8 idle after reset");
        step(1, 0, 16'h0000, 16'h0, "R8 read word 0");
        step(1, 0, 16'h00FE, 16'h0, "R8 read word 127");
        step(0, 0, 16'h0000, 16'h0, "R8 wait");
        step(0, 0, 16'h0000, 16'h0, "R8 readback");

        // R3 and R5: write, blocked rereads, then a read once the bank frees
        step(0, 1, 16'h000A, 16'hBEEF, "R3 write");
        step(1, 0, 16'h000A, 16'h0, "R5 stalled read");
        step(0, 1, 16'h000A, 16'h1111, "R5 stalled write");
        step(1, 0, 16'h000A, 16'h0, "R5 stalled read");
        step(1, 0, 16'h000A, 16'h0, "R3 read after window");
        step(0, 0, 16'h0000, 16'h0, "R3 wait");
        step(0, 0, 16'h0000, 16'h0, "R3 readback");

        // R6: back-to-back requests to all four banks
        step(1, 0, 16'h0010, 16'h0, "R6 bank0");
        step(1, 0, 16'h0012, 16'h0, "R6 bank1");
        step(0, 1, 16'h0014, 16'hA0A0, "R6 bank2");
        step(1, 0, 16'h0016, 16'h0, "R6 bank3");
        step(1, 0, 16'h0018, 16'h0, "R6 bank0 again");
        step(0, 0, 16'h0000, 16'h0, "R6 drain");
        step(0, 0, 16'h0000, 16'h0, "R6 drain");

        // R1: high address bits alias
        step(0, 1, 16'hFE04, 16'h1234, "R1 aliased write");
        step(0, 0, 16'h0000, 16'h0, "R1 wait");
        step(0, 0, 16'h0000, 16'h0, "R1 wait");
        step(0, 0, 16'h0000, 16'h0, "R1 wait");
        step(1, 0, 16'h0004, 16'h0, "R1 read alias");
        step(0, 0, 16'h0000, 16'h0, "R1 wait");
        step(0, 0, 16'h0000, 16'h0, "R1 readback");

        // R7: misaligned and double-strobe requests do nothing
        step(0, 1, 16'h0021, 16'hDEAD, "R7 odd write");
        step(1, 1, 16'h0020, 16'hDEAD, "R7 read and write");
        step(1, 0, 16'h0023, 16'h0, "R7 odd read");
        step(1, 0, 16'h0020, 16'h0, "R7 word unchanged");
        step(0, 0, 16'h0000, 16'h0, "R9 idle");
        step(0, 0, 16'h0000, 16'h0, "R9 idle");

        // Constrained random traffic with a fixed seed
        seed = $urandom(32'd2024);
        for (int n = 0; n < 3000; n++) begin
            int unsigned op;
            logic [15:0] a;
            op = $urandom % 8;
            a  = 16'($urandom);
            if (($urandom % 4) != 0) a = a & 16'h003E;
            if (($urandom % 8) != 0) a[0] = 1'b0;
            case (op)
                0, 1, 2: step(1, 0, a, 16'h0, "random read");
                3, 4, 5: step(0, 1, a, 16'($urandom), "random write");
                6:       step(0, 0, a, 16'h0, "R9 random idle");
                default: step(1, 1, a, 16'($urandom), "R7 random both");
            endcase
        end
        repeat (4) step(0, 0, 16'h0000, 16'h0, "final drain");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule